// File: doc/BRIEF.md
# Serial-Command Calendar Clock

This block is the device end of a calendar clock driven over a three-wire serial link (data in, serial clock, strobe) with a separate data-out line. It counts seconds, minutes, hours, day of month, month, day of week and a two-digit year, and advances one second on each pulse of a tick input. All serial inputs are sampled by the system clock, and their rising edges are found by comparing each input with its value one cycle earlier.

The host shifts a 4-bit command into the device, least significant bit first, and then pulses the strobe to commit it. Four modes are selected this way. Hold freezes the 48-bit time register. Shift moves it one place per serial clock edge. Time set loads the counters from the register and stops them. Time read copies the live counters into the register. In shift mode the 4-bit command stage sits in front of the 48-bit time register. A write is therefore 48 data bits followed by the next 4-bit command, and after those 52 edges the time register holds exactly the 48 data bits.

Top module: `serial_calendar_clock`

## Requirements
- R1: A synchronous active-high reset sets the time to 00:00:00, day 01, month 1, day-of-week 0, year 00. It clears the time register (data out reads 0) and selects hold mode.
- R2: Each rising edge of the serial clock shifts data-in into the top of a 4-bit command stage, so the code arrives least significant bit first. A rising edge of the strobe, sent while the serial clock is low, makes the last four bits the active mode.
- R3: On a strobe with code 3 (time read), the counters are copied into the time register. The register then ignores serial clock edges while code 3 stays active.
- R4: While code 1 (shift) is active, each serial clock rising edge moves bit 0 of the command stage into bit 47 of the time register and shifts the register down one place. Data out always shows register bit 0.
- R5: Time register layout: seconds [7:0], minutes [15:8], hours [23:16], day of month [31:24], day of week [35:32], month [39:36], year [47:40]. The month is binary 1 to 12. Seconds, minutes, hours, day and year are packed BCD.
- R6: On a strobe with code 2 (time set), the time register is copied into the counters. Ticks are ignored while code 2 stays active.
- R7: Under code 0 (hold), and under the unused codes 4 to 15, serial clock edges leave the time register unchanged while ticks keep advancing the time.
- R8: A tick advances seconds. 59 seconds wraps to 00 and carries into minutes, 59 minutes wraps and carries into hours, and hour 23 wraps to 00 and carries into the day.
- R9: The day wraps to 01 after day 28 in month 2, after day 30 in months 4, 6, 9 and 11, and after day 31 otherwise, carrying into the month. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 00.
- R10: The day of week advances with every day change, wrapping from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_stb | input | 1 | Command commit strobe |
| ser_di | input | 1 | Serial data and command input |
| ser_do | output | 1 | Serial read data (time register bit 0) |

## Verification
The assertions assume that the serial clock and the strobe never rise in the same system cycle, and that each level is held for at least one system cycle. They also assume that any time loaded by a set command is a valid calendar value: BCD digits in range, month 1 to 12, and a day no larger than that month allows. The stimulus changes one serial line at a time, holds every level for at least two cycles, raises the strobe only while the serial clock is low, and builds each written time from bench functions that pick only legal field values.

// File: rtl/sccal_pkg.sv
package sccal_pkg;

  localparam int FIELD_W = 8;
  localparam int CMD_W   = 4;

  localparam logic [3:0] CODE_HOLD  = 4'd0;
  localparam logic [3:0] CODE_SHIFT = 4'd1;
  localparam logic [3:0] CODE_SET   = 4'd2;
  localparam logic [3:0] CODE_READ  = 4'd3;

  localparam logic [7:0] LAST_SEC  = 8'h59;
  localparam logic [7:0] LAST_MIN  = 8'h59;
  localparam logic [7:0] LAST_HOUR = 8'h23;
  localparam logic [7:0] LAST_YEAR = 8'h99;
  localparam logic [3:0] LAST_MON  = 4'd12;
  localparam logic [3:0] LAST_DOW  = 4'd6;

  typedef struct packed {
    logic [7:0] year;
    logic [3:0] month;
    logic [3:0] dow;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } caltime_t;

  localparam int TIME_W = $bits(caltime_t);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last_day(input logic [3:0] m);
    case (m)
      4'd2:                     return 8'h28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 8'h30;
      default:                  return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/sccal_front.sv
module sccal_front #(
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_stb,
  input  logic             ser_di,
  output logic             clk_rise,
  output logic             stb_rise,
  output logic [CMD_W-1:0] cmd_q,
  output logic [CMD_W-1:0] mode_q,
  output logic             stage_out
);

  logic clk_d, stb_d;

  assign clk_rise  = ser_clk & ~clk_d;
  assign stb_rise  = ser_stb & ~stb_d;
  assign stage_out = cmd_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d  <= 1'b0;
      stb_d  <= 1'b0;
      cmd_q  <= '0;
      mode_q <= '0;
    end else begin
      clk_d <= ser_clk;
      stb_d <= ser_stb;
      if (clk_rise) cmd_q  <= {ser_di, cmd_q[CMD_W-1:1]};
      if (stb_rise) mode_q <= cmd_q;
    end
  end

endmodule

// File: rtl/sccal_shreg.sv
module sccal_shreg #(
  parameter int SR_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            din,
  input  logic            load_en,
  input  logic [SR_W-1:0] load_val,
  output logic [SR_W-1:0] sr_q
);

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (load_en)  sr_q <= load_val;
    else if (shift_en) sr_q <= {din, sr_q[SR_W-1:1]};
  end

endmodule

// File: rtl/sccal_counters.sv
module sccal_counters
  import sccal_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     hold,
  input  logic     load_en,
  input  caltime_t load_val,
  output caltime_t now_q
);

  caltime_t nxt;
  logic w_sec, w_min, w_hour, w_day, w_mon;

  always_comb begin
    w_sec  = (now_q.sec == LAST_SEC);
    w_min  = w_sec  && (now_q.min == LAST_MIN);
    w_hour = w_min  && (now_q.hour == LAST_HOUR);
    w_day  = w_hour && (now_q.day == month_last_day(now_q.month));
    w_mon  = w_day  && (now_q.month == LAST_MON);

    nxt     = now_q;
    nxt.sec = w_sec ? 8'h00 : bcd_inc(now_q.sec);
    if (w_sec)
      nxt.min = (now_q.min == LAST_MIN) ? 8'h00 : bcd_inc(now_q.min);
    if (w_min)
      nxt.hour = (now_q.hour == LAST_HOUR) ? 8'h00 : bcd_inc(now_q.hour);
    if (w_hour) begin
      nxt.day = w_day ? 8'h01 : bcd_inc(now_q.day);
      nxt.dow = (now_q.dow == LAST_DOW) ? 4'd0 : now_q.dow + 4'd1;
    end
    if (w_day)
      nxt.month = w_mon ? 4'd1 : now_q.month + 4'd1;
    if (w_mon)
      nxt.year = (now_q.year == LAST_YEAR) ? 8'h00 : bcd_inc(now_q.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q       <= '0;
      now_q.day   <= 8'h01;
      now_q.month <= 4'd1;
    end else if (load_en) begin
      now_q <= load_val;
    end else if (tick && !hold) begin
      now_q <= nxt;
    end
  end

endmodule

// File: rtl/serial_calendar_clock.sv
module serial_calendar_clock
  import sccal_pkg::*;
#(
  parameter int CMD_W = sccal_pkg::CMD_W
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic ser_clk,
  input  logic ser_stb,
  input  logic ser_di,
  output logic ser_do
);

  localparam int SR_W = TIME_W;

  logic             clk_rise, stb_rise, stage_out;
  logic [CMD_W-1:0] cmd_q, mode_q;
  logic [SR_W-1:0]  shreg_q;
  caltime_t         time_q;
  logic             do_shift, do_read, do_set, cnt_hold;

  assign do_shift = clk_rise && !stb_rise && (mode_q == CMD_W'(CODE_SHIFT));
  assign do_read  = stb_rise && (cmd_q == CMD_W'(CODE_READ));
  assign do_set   = stb_rise && (cmd_q == CMD_W'(CODE_SET));
  assign cnt_hold = (mode_q == CMD_W'(CODE_SET));

  sccal_front #(.CMD_W(CMD_W)) u_front (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .ser_stb   (ser_stb),
    .ser_di    (ser_di),
    .clk_rise  (clk_rise),
    .stb_rise  (stb_rise),
    .cmd_q     (cmd_q),
    .mode_q    (mode_q),
    .stage_out (stage_out)
  );

  sccal_shreg #(.SR_W(SR_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (do_shift),
    .din      (stage_out),
    .load_en  (do_read),
    .load_val (time_q),
    .sr_q     (shreg_q)
  );

  sccal_counters u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .hold     (cnt_hold),
    .load_en  (do_set),
    .load_val (caltime_t'(shreg_q)),
    .now_q    (time_q)
  );

  assign ser_do = shreg_q[0];

endmodule

// File: rtl/sccal_checker.sv
module sccal_checker #(
  parameter int CMD_W = 4,
  parameter int SR_W  = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_clk,
  input logic             ser_stb,
  input logic [CMD_W-1:0] mode,
  input logic [CMD_W-1:0] cmd,
  input logic [SR_W-1:0]  shreg,
  input logic [SR_W-1:0]  tnow
);

  assert_mode_commit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_stb) |=> mode == $past(cmd));

  assert_read_load_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(ser_stb) && cmd == CMD_W'(3)) |=> shreg == $past(tnow));

  assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == CMD_W'(1) && $rose(ser_clk) && !$rose(ser_stb))
      |=> shreg == {$past(cmd[0]), $past(shreg[SR_W-1:1])});

  assert_set_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == CMD_W'(2) && !$rose(ser_stb)) |=> $stable(tnow));

  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (mode != CMD_W'(1) && !$rose(ser_stb)) |=> $stable(shreg));

  assert_sec_range_R8: assert property (@(posedge clk) disable iff (rst)
    tnow[7:0] <= 8'h59 && tnow[3:0] <= 4'd9);

  assert_month_range_R9: assert property (@(posedge clk) disable iff (rst)
    tnow[39:36] >= 4'd1 && tnow[39:36] <= 4'd12);

  assert_dow_range_R10: assert property (@(posedge clk) disable iff (rst)
    tnow[35:32] <= 4'd6);

endmodule

bind serial_calendar_clock sccal_checker #(.CMD_W(CMD_W), .SR_W(SR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ser_clk (ser_clk),
  .ser_stb (ser_stb),
  .mode    (mode_q),
  .cmd     (cmd_q),
  .shreg   (shreg_q),
  .tnow    (time_q)
);

// File: tb/tb_serial_calendar_clock.sv
module tb_serial_calendar_clock;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0, ser_clk = 1'b0, ser_stb = 1'b0, ser_di = 1'b0;
  logic ser_do;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  // model state (binary)
  int m_s, m_mi, m_h, m_d, m_mo, m_dw, m_y;

  always #10 clk = ~clk;

  serial_calendar_clock dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .ser_clk(ser_clk), .ser_stb(ser_stb), .ser_di(ser_di), .ser_do(ser_do)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo);
    if (mo == 2) return 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [47:0] model_word();
    return {to_bcd(m_y), 4'(m_mo), 4'(m_dw), to_bcd(m_d),
            to_bcd(m_h), to_bcd(m_mi), to_bcd(m_s)};
  endfunction

  task automatic model_set(input int s, mi, h, d, mo, dw, y);
    m_s = s; m_mi = mi; m_h = h; m_d = d; m_mo = mo; m_dw = dw; m_y = y;
  endtask

  task automatic model_tick();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0; m_dw = (m_dw + 1) % 7; m_d++;
          if (m_d > days_in(m_mo)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [47:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic o);
    @(negedge clk); o = ser_do; ser_di = b;
    @(negedge clk); ser_clk = 1'b1;
    repeat (2) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_cmd(input logic [3:0] c);
    logic o;
    for (int i = 0; i < 4; i++) clk_bit(c[i], o);
    @(negedge clk); ser_stb = 1'b1;
    repeat (2) @(negedge clk);
    ser_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_time(input logic [47:0] w, input int ticks_in_set);
    logic o;
    send_cmd(4'd1);
    for (int i = 0; i < 48; i++) clk_bit(w[i], o);
    send_cmd(4'd2);
    for (int i = 0; i < ticks_in_set; i++) pulse_tick();
    send_cmd(4'd0);
  endtask

  task automatic shift_out(output logic [47:0] r);
    logic o;
    for (int i = 0; i < 48; i++) begin clk_bit(1'b0, o); r[i] = o; end
  endtask

  task automatic read_time(output logic [47:0] r);
    send_cmd(4'd3);
    send_cmd(4'd1);
    shift_out(r);
    send_cmd(4'd0);
  endtask

  task automatic pulse_tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic roll_case(input string tag, input int s, mi, h, d, mo, dw, y);
    logic [47:0] r;
    model_set(s, mi, h, d, mo, dw, y);
    write_time(model_word(), 0);
    pulse_tick(); model_tick();
    read_time(r);
    check(r == model_word(), tag, r, model_word());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [47:0] r, w;
    logic o;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check(ser_do == 1'b0, "R1 data out after reset", 48'(ser_do), 48'h0);
    model_set(0, 0, 0, 1, 1, 0, 0);
    read_time(r);
    check(r == 48'h00_10_01_00_00_00, "R1 R5 reset time", r, 48'h00_10_01_00_00_00);

    // R2 R4 R5: write and read back a fixed time
    model_set(56, 34, 12, 15, 7, 3, 24);
    w = model_word();
    check(w == 48'h24_73_15_12_34_56, "R5 bench layout", w, 48'h24_73_15_12_34_56);
    write_time(w, 0);
    send_cmd(4'd3);
    send_cmd(4'd1);
    @(negedge clk);
    check(ser_do == w[0], "R4 data out shows bit 0", 48'(ser_do), 48'(w[0]));
    shift_out(r);
    send_cmd(4'd0);
    check(r == w, "R2 R4 round trip", r, w);

    // R6: ticks ignored while time-set mode is active
    model_set(10, 20, 5, 9, 3, 1, 50);
    write_time(model_word(), 3);
    read_time(r);
    check(r == model_word(), "R6 counters held in set mode", r, model_word());

    // R7: hold and unused code freeze the register; time keeps running
    model_set(30, 0, 1, 2, 5, 4, 10);
    write_time(model_word(), 0);
    send_cmd(4'd3);
    send_cmd(4'd0);
    for (int i = 0; i < 5; i++) clk_bit(1'($urandom), o);
    send_cmd(4'd9);
    for (int i = 0; i < 3; i++) clk_bit(1'($urandom), o);
    pulse_tick(); pulse_tick();
    send_cmd(4'd1);
    shift_out(r);
    send_cmd(4'd0);
    check(r == model_word(), "R7 register frozen in hold", r, model_word());
    model_tick(); model_tick();
    read_time(r);
    check(r == model_word(), "R7 time advances in hold", r, model_word());

    // R8 R9 R10: rollover corners
    roll_case("R8 seconds carry", 59, 0, 0, 1, 1, 0, 0);
    roll_case("R8 minute carry", 59, 59, 0, 1, 1, 0, 0);
    roll_case("R8 hour carry", 59, 59, 23, 10, 6, 2, 33);
    roll_case("R9 R10 new year", 59, 59, 23, 31, 12, 6, 99);
    roll_case("R9 february end", 59, 59, 23, 28, 2, 1, 21);
    roll_case("R9 thirty day month", 59, 59, 23, 30, 4, 5, 7);
    roll_case("R9 no wrap on day 29", 59, 59, 23, 29, 6, 0, 12);
    roll_case("R9 thirty one day month", 59, 59, 23, 31, 8, 3, 45);
    roll_case("R10 dow wrap", 59, 59, 23, 5, 9, 6, 1);

    // random valid times, random tick counts
    for (int it = 0; it < 30; it++) begin
      int mo, k;
      mo = 1 + int'($urandom % 12);
      model_set(($urandom % 2) ? 59 : int'($urandom % 60),
                ($urandom % 2) ? 59 : int'($urandom % 60),
                ($urandom % 2) ? 23 : int'($urandom % 24),
                ($urandom % 2) ? days_in(mo) : 1 + int'($urandom % days_in(mo)),
                mo, int'($urandom % 7), int'($urandom % 100));
      write_time(model_word(), 0);
      k = int'($urandom % 4);
      for (int j = 0; j < k; j++) begin pulse_tick(); model_tick(); end
      read_time(r);
      check(r == model_word(), "R8 R9 R10 random time", r, model_word());
    end

    done = 1'b1;
    summary();
  end

endmodule